// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a small byte-wide register target that runs one serial flash transaction per start request. Software loads a command byte into a dedicated register, packs the transmit and receive lengths into a second register, and fills a shared eight-entry data buffer through a single data port. It then sets the start bit and polls until the engine goes idle.

The engine drives chip select low and sends the command byte, followed by the staged transmit bytes. It then clocks in the requested number of receive bytes. The serial link uses mode 0: the clock idles low, the slave samples on the rising edge, and data changes on the falling edge. Each clock half period lasts `HALF_DIV` system clocks. Received bytes are stored in the same buffer, directly after the transmit bytes. After rewinding the buffer pointer, software reads past its own transmit bytes to reach the response.

Top module: `spi_cmd_engine`

## Requirements
- R1: The command byte is held at offset 0x0. It goes out as the first byte of every transaction, MSB first, and never occupies a buffer entry.
- R2: Offset 0x1 holds the transmit length in bits 3:0 and the receive length in bits 7:4. Both read back as written. A transmit length above 8 is treated as 8.
- R3: When the transmit length is zero, the engine receives one byte fewer than the programmed receive length, or none when that length is zero. With a nonzero transmit length, it receives exactly the programmed number.
- R4: Writing 1 to bit 0 of offset 0x2 starts a transaction. While the engine is active, bit 0 of offset 0x2 and bit 7 of offset 0x3 both read 1. Both read 0 when the engine is idle.
- R5: Writing 1 to bit 4 of offset 0x2 returns the buffer pointer to 0. Offset 0xD returns the pointer in bits 2:0, and that bit 4 always reads as 0.
- R6: A write to offset 0xC stores the byte at the pointer, and a read returns the byte at the pointer. Each of these accesses advances the pointer by one, wrapping from 7 to 0.
- R7: After a transaction, buffer entries 0 to T-1 hold the T transmit bytes and entries T onward hold the received bytes in arrival order, at index modulo 8.
- R8: Chip select is low only while active, and the serial clock is low whenever chip select is high. MOSI holds steady while the serial clock is high. Chip select rises on the falling edge that follows the last sampled bit.
- R9: While the engine is active, writes to offsets 0x0, 0x1 and 0xC and further start requests have no effect.
- R10: A transaction produces exactly 8*(1+T+R) rising edges of the serial clock, where T and R are the effective transmit and receive lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench goes after the zero-transmit case, where an engine without the length adjustment would clock one byte too many, and after a receive phase long enough to wrap the buffer, where a wrong store index would leave the response in the wrong entries. It checks the pointer wrap on the data port. It also covers a transmit length of 15, which a design without the clamp would turn into an overlong transaction. Writes and a second start request during a running transaction would, in a faulty design, corrupt the command, the lengths, or the pointer, or restart the shifter. The bench exposes these through register readback and the edge count.

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int HALF_DIV = 2,
  parameter int DEPTH    = 8,
  parameter int MAX_TX   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       spi_cs_n,
  output logic       spi_sck,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  localparam int PW = $clog2(DEPTH);
  localparam int DW = $clog2(HALF_DIV) + 1;

  logic [7:0]    opcode_q, count_q, txsr_q, rxsr_q;
  logic [7:0]    fifo_q [DEPTH];
  logic [PW-1:0] ptr_q;
  logic          busy_q, sck_q, cs_n_q;
  logic [2:0]    bit_q;
  logic [4:0]    byte_q;
  logic [DW-1:0] div_q;

  logic [3:0] n_tx, n_rx;
  logic [4:0] last_byte, next_byte;
  logic [7:0] next_tx, rx_byte;
  logic       tick, wr_op, wr_cnt, wr_ctl, start, ptr_clr, wr_dat, rd_dat, rx_store;

  assign n_tx      = (count_q[3:0] > 4'(MAX_TX)) ? 4'(MAX_TX) : count_q[3:0];
  assign n_rx      = (n_tx == 4'd0 && count_q[7:4] != 4'd0) ? count_q[7:4] - 4'd1 : count_q[7:4];
  assign last_byte = {1'b0, n_tx} + {1'b0, n_rx};
  assign next_byte = byte_q + 5'd1;
  assign next_tx   = (next_byte <= {1'b0, n_tx}) ? fifo_q[PW'(byte_q)] : 8'h00;
  assign rx_byte   = {rxsr_q[6:0], spi_miso};
  assign tick      = (div_q == DW'(HALF_DIV - 1));

  assign wr_op   = bus_wr && bus_addr == 4'h0 && !busy_q;
  assign wr_cnt  = bus_wr && bus_addr == 4'h1 && !busy_q;
  assign wr_ctl  = bus_wr && bus_addr == 4'h2;
  assign start   = wr_ctl && bus_wdata[0] && !busy_q;
  assign ptr_clr = wr_ctl && bus_wdata[4];
  assign wr_dat  = bus_wr && bus_addr == 4'hC && !busy_q;
  assign rd_dat  = bus_rd && bus_addr == 4'hC;
  assign rx_store = busy_q && tick && !sck_q && bit_q == 3'd7 && byte_q > {1'b0, n_tx};

  assign spi_cs_n = cs_n_q;
  assign spi_sck  = sck_q;
  assign spi_mosi = txsr_q[7];

  always_comb begin
    case (bus_addr)
      4'h0:    bus_rdata = opcode_q;
      4'h1:    bus_rdata = count_q;
      4'h2:    bus_rdata = {7'b0, busy_q};
      4'h3:    bus_rdata = {busy_q, 7'b0};
      4'hC:    bus_rdata = fifo_q[ptr_q];
      4'hD:    bus_rdata = {{(8-PW){1'b0}}, ptr_q};
      default: bus_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode_q <= 8'h00;
      count_q  <= 8'h00;
      ptr_q    <= '0;
    end else begin
      if (wr_op)  opcode_q <= bus_wdata;
      if (wr_cnt) count_q  <= bus_wdata;
      if (ptr_clr)              ptr_q <= '0;
      else if (wr_dat || rd_dat) ptr_q <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_dat)        fifo_q[ptr_q] <= bus_wdata;
    else if (rx_store) fifo_q[PW'(byte_q - 5'd1)] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cs_n_q <= 1'b1;
      sck_q  <= 1'b0;
      div_q  <= '0;
      bit_q  <= 3'd0;
      byte_q <= 5'd0;
      txsr_q <= 8'h00;
      rxsr_q <= 8'h00;
    end else if (start) begin
      busy_q <= 1'b1;
      cs_n_q <= 1'b0;
      sck_q  <= 1'b0;
      div_q  <= '0;
      bit_q  <= 3'd0;
      byte_q <= 5'd0;
      txsr_q <= opcode_q;
    end else if (busy_q) begin
      if (!tick) begin
        div_q <= div_q + 1'b1;
      end else begin
        div_q <= '0;
        if (!sck_q) begin
          sck_q  <= 1'b1;
          rxsr_q <= rx_byte;
        end else begin
          sck_q <= 1'b0;
          bit_q <= bit_q + 3'd1;
          if (bit_q != 3'd7) begin
            txsr_q <= {txsr_q[6:0], 1'b0};
          end else if (byte_q == last_byte) begin
            busy_q <= 1'b0;
            cs_n_q <= 1'b1;
          end else begin
            byte_q <= next_byte;
            txsr_q <= next_tx;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    bus_addr,
  input logic          bus_wr,
  input logic [7:0]    bus_wdata,
  input logic          spi_cs_n,
  input logic          spi_sck,
  input logic          spi_mosi,
  input logic          busy,
  input logic [7:0]    opcode,
  input logic [7:0]    count,
  input logic [PW-1:0] ptr
);
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) spi_cs_n |-> !spi_sck); // R8
  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!spi_cs_n && spi_sck) |=> (!spi_sck || $stable(spi_mosi))); // R8
  AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (!busy && bus_wr && bus_addr == 4'h2 && bus_wdata[0]) |=> (busy && !spi_cs_n)); // R4
  AST_OPCODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) (busy && bus_wr && bus_addr == 4'h0) |=> $stable(opcode)); // R9
  AST_COUNT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) (busy && bus_wr && bus_addr == 4'h1) |=> $stable(count)); // R9
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr && bus_addr == 4'h2 && bus_wdata[4]) |=> ptr == '0); // R5
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (!busy && bus_wr && bus_addr == 4'hC) |=> ptr == PW'($past(ptr) + 1'b1)); // R6
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
  .busy(busy_q), .opcode(opcode_q), .count(count_q), .ptr(ptr_q)
);

// File: tb/spi_cmd_engine_test.sv
module spi_cmd_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // op[87:80] cnt[79:72] tx bytes[71:8] seed[7:0]
  localparam logic [87:0] VEC [NVEC] = '{
    {8'h03, 8'h40, 64'h0, 8'h11},
    {8'h02, 8'h04, 64'h11223344_00000000, 8'h22},
    {8'h0B, 8'h35, 64'hA1B2C3D4_E5000000, 8'h33},
    {8'h9F, 8'h00, 64'h0, 8'h44},
    {8'hAB, 8'h08, 64'h01020304_05060708, 8'h55},
    {8'h05, 8'h22, 64'hDEAD0000_00000000, 8'h66},
    {8'h3B, 8'h63, 64'h7E81C300_00000000, 8'h77},
    {8'h06, 8'h10, 64'h0, 8'h88}
  };

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic spi_cs_n, spi_sck, spi_mosi, spi_miso;
  int checks = 0, fails = 0, nbits = 0;
  logic [7:0] seed = 0;
  logic [7:0] cap [32];

  spi_cmd_engine uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] resp(logic [7:0] s, int j);
    return s ^ 8'hA5 ^ 8'(j * 29);
  endfunction

  always_comb begin
    logic [7:0] b;
    b = resp(seed, nbits / 8);
    spi_miso = b[7 - (nbits % 8)];
  end

  always @(posedge spi_sck or negedge spi_cs_n) begin
    if (!spi_cs_n && spi_sck) begin
      if (nbits < 256) cap[nbits/8] = {cap[nbits/8][6:0], spi_mosi};
      nbits = nbits + 1;
    end else if (!spi_cs_n) nbits = 0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 0;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 2000; i++) begin
      rd(4'h2, v);
      if (!v[0]) break;
    end
  endtask

  task automatic run(input logic [87:0] v);
    logic [7:0] op, cn, d, tx [8], exp [8];
    int t, r, rx, n;
    op = v[87:80]; cn = v[79:72]; seed = v[7:0];
    for (int i = 0; i < 8; i++) tx[i] = v[71 - 8*i -: 8];
    t = (cn[3:0] > 8) ? 8 : cn[3:0];
    r = cn[7:4];
    rx = (t == 0 && r != 0) ? r - 1 : r;
    wr(4'h1, cn); wr(4'h0, op); wr(4'h2, 8'h10);
    rd(4'hD, d); chk(d == 0, "R5 ptr after clear", d, 0);
    for (int i = 0; i < t; i++) wr(4'hC, tx[i]);
    wr(4'h2, 8'h10); wr(4'h2, 8'h01);
    rd(4'h3, d); chk(d[7], "R4 busy flag", d, 8'h80);
    wait_idle();
    rd(4'h3, d); chk(d == 0, "R4 idle flag", d, 0);
    chk(nbits == 8*(1+t+rx), "R10/R3 edge count", nbits, 8*(1+t+rx));
    chk(cap[0] == op, "R1 command byte", cap[0], op);
    for (int i = 0; i < t; i++) chk(cap[1+i] == tx[i], "R1 tx byte order", cap[1+i], tx[i]);
    for (int i = 0; i < t; i++) exp[i] = tx[i];
    for (int k = 0; k < rx; k++) exp[(t+k)%8] = resp(seed, 1+t+k);
    n = (t + rx > 8) ? 8 : t + rx;
    wr(4'h2, 8'h10);
    for (int i = 0; i < n; i++) begin
      rd(4'hC, d); chk(d == exp[i], "R7 buffer content", d, exp[i]);
    end
    rd(4'h1, d); chk(d == cn, "R2 count readback", d, cn);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R8 reset pins", {spi_cs_n, spi_sck}, 2'b10);
    rd(4'h0, d); chk(d == 0, "R1 reset opcode", d, 0);
    rd(4'h2, d); chk(d == 0, "R4 reset control", d, 0);
    rd(4'h3, d); chk(d == 0, "R4 reset status", d, 0);
    rd(4'hD, d); chk(d == 0, "R5 reset pointer", d, 0);

    for (int i = 0; i < NVEC; i++) run(VEC[i]);

    // R6 wrap on data port
    wr(4'h2, 8'h10);
    for (int i = 0; i < 9; i++) wr(4'hC, 8'(8'h40 + i));
    rd(4'hD, d); chk(d == 1, "R6 pointer wrap", d, 1);
    wr(4'h2, 8'h10);
    rd(4'hC, d); chk(d == 8'h48, "R6 overwrite after wrap", d, 8'h48);
    rd(4'h2, d); chk(d[4] == 0, "R5 clear bit reads zero", d, 0);

    // R2 clamp of transmit length 15 to 8
    run({8'hC7, 8'h0F, 64'h0102030405060708, 8'h99});

    // R9 writes ignored while busy
    wr(4'h1, 8'h08); wr(4'h0, 8'h77); wr(4'h2, 8'h10);
    for (int i = 0; i < 8; i++) wr(4'hC, 8'(i));
    wr(4'h2, 8'h01);
    rd(4'h2, d); chk(d[0], "R4 start bit reads busy", d, 1);
    wr(4'hC, 8'h55);
    rd(4'hD, d); chk(d == 0, "R9 fifo write ignored", d, 0);
    wr(4'h0, 8'h12); wr(4'h1, 8'hFF);
    repeat (20) @(posedge clk);
    wr(4'h2, 8'h01);
    wait_idle();
    rd(4'h0, d); chk(d == 8'h77, "R9 opcode locked", d, 8'h77);
    rd(4'h1, d); chk(d == 8'h08, "R9 count locked", d, 8'h08);
    chk(nbits == 72, "R9 no restart", nbits, 72);
    rd(4'hC, d); chk(d == 8'h00, "R9 entry 0 intact", d, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule